// File: doc/BRIEF.md
# Interleaved Channel Offset and Gain Equalizer

This block sits after a time-interleaved converter whose sub-converter outputs have already been multiplexed into one stream. Each clock may carry one signed sample with a tag that names the sub-converter it came from. Sample k of the stream belongs to channel k mod NCH. The block works out a DC offset for every channel and removes it. It then scales each channel so that its power matches channel 0, which acts as the reference. The corrected stream leaves with the same tags. The current offset and gain of every channel are also driven out so they can be observed.

Every channel is estimated on its own, over windows of 2^LOG2N valid samples of that channel. The offset is the floor of the window mean of the raw samples. The power is the sum of squares of the offset-corrected samples over the same window. When channel NCH-1 closes a window, a sequential solver works out the gains of channels 1 to NCH-1 one after another. Each gain is an unsigned Q2.14 value: the square root of the reference power divided by that channel's power. The stream never stalls. A window that ends while the solver is still busy updates the offsets but not the gains.

Top module: `oge_equalizer`

## Requirements
- R1: Reset leaves every offset at 0, every gain at 16384 (1.0 in unsigned Q2.14), and out_valid low.
- R2: out_valid is in_valid delayed by exactly 3 clock cycles, and out_chan is the in_chan of that same sample. Every valid input produces exactly one output.
- R3: After every 2^LOG2N-th valid sample of channel c, the offset of channel c becomes floor(sum of that window's raw samples / 2^LOG2N). It is applied from the next sample of channel c onward; the sample that closes the window still uses the old offset. Channel c's offset appears on est_offset[c*DW +: DW] in two's complement.
- R4: The power of channel c is the sum over its window of (x - offset)^2, where offset is the value in use during that window.
- R5: Channel 0's gain stays at 16384 at all times.
- R6: When channel NCH-1 closes a window, the gain of each channel i from 1 to NCH-1 becomes floor(sqrt(floor(P0 * 2^28 / Pi))). The powers used are those of the windows just completed. The new gains appear on est_gain[16*i +: 16] within 160 cycles.
- R7: If Pi is 0, gain i becomes 16384. If P0 >= 16*Pi, gain i becomes 65535.
- R8: out_data equals (x - offset) * gain shifted right arithmetically by 14 (floor), saturated to the DW-bit signed range [-2^(DW-1), 2^(DW-1)-1].
- R9: Cycles with in_valid low change no estimate and produce no output, whatever in_chan and in_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_chan | input | $clog2(NCH) | Channel tag of the input sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_chan | output | $clog2(NCH) | Channel tag of the output sample |
| out_data | output | DW | Corrected signed sample |
| est_offset | output | NCH*DW | Per-channel offset estimates, channel c at bits c*DW upward |
| est_gain | output | NCH*16 | Per-channel Q2.14 gains, channel c at bits 16*c upward |

## Verification
A wrong accumulator or offset register shows on est_offset at the very next window close of that channel. It also shows in that channel's corrected samples one pipeline latency (three cycles) later. A solver fault, whether in the quotient, the root or the channel index, shows on est_gain about 150 cycles after channel NCH-1 closes a window. It then shows in every later output of the affected channel as a scaled or saturated value. A pipeline or tag slip shows on the first valid output, as a wrong channel tag or a valid that arrives a cycle off.

// File: rtl/oge_pkg.sv
package oge_pkg;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 14;
  localparam int QUO_W     = 2 * GAIN_W;
  localparam logic [GAIN_W-1:0] GAIN_ONE = 16'h4000;
  localparam logic [GAIN_W-1:0] GAIN_MAX = 16'hFFFF;

  typedef enum logic [2:0] {
    SV_IDLE,
    SV_PREP,
    SV_DIV,
    SV_ROOT,
    SV_WRITE
  } solve_state_e;
endpackage

// File: rtl/oge_window_acc.sv
module oge_window_acc #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LOG2N = 10,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = DW + LOG2N,
  localparam int PW   = 2 * (DW + 1) + LOG2N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_chan,
  input  logic signed [DW-1:0] in_data,
  output logic [NCH*DW-1:0]    off_flat,
  output logic [NCH*PW-1:0]    pw_flat,
  output logic                 round_done
);
  logic [NCH-1:0] close_v;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic signed [SW-1:0]     sum_q;
    logic [PW-1:0]            sq_q;
    logic [LOG2N-1:0]         cnt_q;
    logic signed [DW-1:0]     off_q;
    logic [PW-1:0]            pw_q;
    logic                     hit;
    logic signed [DW:0]       dev;
    logic signed [2*DW+1:0]   dev_sq;
    logic signed [SW-1:0]     sum_nx;
    logic [PW-1:0]            sq_nx;

    assign hit    = in_valid && (in_chan == CW'(c));
    assign dev    = {in_data[DW-1], in_data} - {off_q[DW-1], off_q};
    assign dev_sq = dev * dev;
    assign sum_nx = sum_q + SW'(in_data);
    assign sq_nx  = sq_q + PW'($unsigned(dev_sq));
    assign close_v[c] = hit && (cnt_q == '1);

    always_ff @(posedge clk) begin
      if (rst) begin
        sum_q <= '0;
        sq_q  <= '0;
        cnt_q <= '0;
        off_q <= '0;
        pw_q  <= '0;
      end else if (hit) begin
        cnt_q <= cnt_q + 1'b1;
        if (close_v[c]) begin
          off_q <= DW'(sum_nx >>> LOG2N);
          pw_q  <= sq_nx;
          sum_q <= '0;
          sq_q  <= '0;
        end else begin
          sum_q <= sum_nx;
          sq_q  <= sq_nx;
        end
      end
    end

    assign off_flat[c*DW +: DW] = off_q;
    assign pw_flat[c*PW +: PW]  = pw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) round_done <= 1'b0;
    else     round_done <= close_v[NCH-1];
  end
endmodule

// File: rtl/oge_gain_solver.sv
module oge_gain_solver
  import oge_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 36,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW = PW + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NCH*PW-1:0]       pw_flat,
  output logic [NCH*GAIN_W-1:0]   gain_flat
);
  solve_state_e        st_q;
  logic [NCH*PW-1:0]   snap_q;
  logic [CW-1:0]       idx_q;
  logic [RW-1:0]       rem_q;
  logic [RW-1:0]       dvs_q;
  logic [QUO_W-1:0]    quo_q;
  logic [4:0]          step_q;
  logic [GAIN_W-1:0]   root_q;
  logic [3:0]          rbit_q;
  logic [GAIN_W-1:0]   gain_q [NCH];

  logic [PW-1:0]       p_ref;
  logic [PW-1:0]       p_cur;
  logic [GAIN_W-1:0]   trial;
  logic [QUO_W-1:0]    trial_sq;

  assign p_ref    = snap_q[PW-1:0];
  assign p_cur    = snap_q[idx_q*PW +: PW];
  assign trial    = root_q | (GAIN_W'(1) << rbit_q);
  assign trial_sq = QUO_W'(trial) * QUO_W'(trial);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SV_IDLE;
      snap_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      root_q <= '0;
      rbit_q <= '0;
      for (int c = 0; c < NCH; c++) gain_q[c] <= GAIN_ONE;
    end else begin
      case (st_q)
        SV_IDLE: begin
          if (start) begin
            snap_q <= pw_flat;
            idx_q  <= CW'(1);
            st_q   <= SV_PREP;
          end
        end
        SV_PREP: begin
          if (p_cur == '0) begin
            root_q <= GAIN_ONE;
            st_q   <= SV_WRITE;
          end else if ({4'b0, p_ref} >= {p_cur, 4'b0}) begin
            root_q <= GAIN_MAX;
            st_q   <= SV_WRITE;
          end else begin
            rem_q  <= RW'(p_ref);
            dvs_q  <= {1'b0, p_cur, 3'b000};
            quo_q  <= '0;
            step_q <= 5'd31;
            st_q   <= SV_DIV;
          end
        end
        SV_DIV: begin
          if (rem_q >= dvs_q) begin
            rem_q         <= (rem_q - dvs_q) << 1;
            quo_q[step_q] <= 1'b1;
          end else begin
            rem_q <= rem_q << 1;
          end
          if (step_q == 5'd0) begin
            root_q <= '0;
            rbit_q <= 4'd15;
            st_q   <= SV_ROOT;
          end else begin
            step_q <= step_q - 1'b1;
          end
        end
        SV_ROOT: begin
          if (trial_sq <= quo_q) root_q <= trial;
          if (rbit_q == 4'd0) st_q <= SV_WRITE;
          else                rbit_q <= rbit_q - 1'b1;
        end
        SV_WRITE: begin
          gain_q[idx_q] <= root_q;
          if (idx_q == CW'(NCH - 1)) begin
            st_q <= SV_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SV_PREP;
          end
        end
        default: st_q <= SV_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign gain_flat[c*GAIN_W +: GAIN_W] = gain_q[c];
  end
endmodule

// File: rtl/oge_correct_pipe.sv
module oge_correct_pipe
  import oge_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 12,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PRW = DW + GAIN_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CW-1:0]           in_chan,
  input  logic signed [DW-1:0]    in_data,
  input  logic [NCH*DW-1:0]       off_flat,
  input  logic [NCH*GAIN_W-1:0]   gain_flat,
  output logic                    out_valid,
  output logic [CW-1:0]           out_chan,
  output logic signed [DW-1:0]    out_data
);
  logic                  v1, v2;
  logic [CW-1:0]         c1, c2;
  logic signed [DW:0]    d1;
  logic signed [PRW-1:0] p2;
  logic signed [DW-1:0]  off_sel;
  logic [GAIN_W-1:0]     g_sel;
  logic signed [PRW-1:0] scaled;
  logic signed [DW-1:0]  y_nx;

  assign off_sel = off_flat[in_chan*DW +: DW];
  assign g_sel   = gain_flat[c1*GAIN_W +: GAIN_W];
  assign scaled  = p2 >>> GAIN_FRAC;

  always_comb begin
    if ((scaled[PRW-1:DW-1] == '0) || (scaled[PRW-1:DW-1] == '1))
      y_nx = scaled[DW-1:0];
    else if (scaled[PRW-1])
      y_nx = {1'b1, {(DW-1){1'b0}}};
    else
      y_nx = {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      c1        <= '0;
      c2        <= '0;
      out_chan  <= '0;
      d1        <= '0;
      p2        <= '0;
      out_data  <= '0;
    end else begin
      v1        <= in_valid;
      c1        <= in_chan;
      d1        <= {in_data[DW-1], in_data} - {off_sel[DW-1], off_sel};
      v2        <= v1;
      c2        <= c1;
      p2        <= d1 * $signed({1'b0, g_sel});
      out_valid <= v2;
      out_chan  <= c2;
      out_data  <= y_nx;
    end
  end
endmodule

// File: rtl/oge_equalizer.sv
module oge_equalizer
  import oge_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LOG2N = 10,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PW   = 2 * (DW + 1) + LOG2N
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CW-1:0]           in_chan,
  input  logic signed [DW-1:0]    in_data,
  output logic                    out_valid,
  output logic [CW-1:0]           out_chan,
  output logic signed [DW-1:0]    out_data,
  output logic [NCH*DW-1:0]       est_offset,
  output logic [NCH*GAIN_W-1:0]   est_gain
);
  logic [NCH*DW-1:0]     off_flat;
  logic [NCH*PW-1:0]     pw_flat;
  logic                  round_done;
  logic [NCH*GAIN_W-1:0] gain_flat;

  oge_window_acc #(.NCH(NCH), .DW(DW), .LOG2N(LOG2N)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_data    (in_data),
    .off_flat   (off_flat),
    .pw_flat    (pw_flat),
    .round_done (round_done)
  );

  oge_gain_solver #(.NCH(NCH), .PW(PW)) u_solver (
    .clk       (clk),
    .rst       (rst),
    .start     (round_done),
    .pw_flat   (pw_flat),
    .gain_flat (gain_flat)
  );

  oge_correct_pipe #(.NCH(NCH), .DW(DW)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .off_flat  (off_flat),
    .gain_flat (gain_flat),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

  assign est_offset = off_flat;
  assign est_gain   = gain_flat;
endmodule

// File: rtl/oge_equalizer_chk.sv
module oge_equalizer_chk #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LOG2N = 10,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GW   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CW-1:0]     in_chan,
  input logic              out_valid,
  input logic [CW-1:0]     out_chan,
  input logic [NCH*DW-1:0] est_offset,
  input logic [NCH*GW-1:0] est_gain
);
  logic [2:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  // R2: valid and tag come out three cycles after they go in
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 3'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_tag_R2: assert property (@(posedge clk) disable iff (rst)
    ((age_q >= 3'd3) && out_valid) |-> (out_chan == $past(in_chan, 3)));

  // R5: the reference channel keeps unity gain
  assert_ref_unity_R5: assert property (@(posedge clk) disable iff (rst)
    (est_gain[GW-1:0] == 16'h4000));

  // R9: a cycle without a valid sample leaves every offset as it was
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((age_q != 3'd0) && !$past(in_valid)) |-> $stable(est_offset));

  for (genvar c = 0; c < NCH; c++) begin : g_own
    // R3: an offset moves only after a sample of its own channel
    assert_offset_own_R3: assert property (@(posedge clk) disable iff (rst)
      ((age_q != 3'd0) && !$stable(est_offset[c*DW +: DW]))
        |-> $past(in_valid && (in_chan == CW'(c))));
  end
endmodule

bind oge_equalizer oge_equalizer_chk #(.NCH(NCH), .DW(DW), .LOG2N(LOG2N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_chan    (in_chan),
  .out_valid  (out_valid),
  .out_chan   (out_chan),
  .est_offset (est_offset),
  .est_gain   (est_gain)
);

// File: tb/oge_equalizer_tb.sv
module oge_equalizer_tb;
  localparam int NCH    = 4;
  localparam int DW     = 12;
  localparam int LOG2N  = 7;
  localparam int CW     = 2;
  localparam int GW     = 16;
  localparam int NWIN   = 1 << LOG2N;
  localparam int ROUND  = NCH * NWIN;
  localparam int NROUND = 3;
  localparam int NSMP   = ROUND * NROUND;
  localparam int NSCN   = 4;
  localparam int YMAX   = (1 << (DW - 1)) - 1;
  localparam int YMIN   = -(1 << (DW - 1));

  // per scenario: offset[4], amplitude rounds 0-1 [4], amplitude round 2 [4], gap flag
  localparam int SCN [NSCN][13] = '{
    '{0, 0, 0, 0,       64, 64, 64, 64,    64, 64, 64, 64,    0},
    '{100, -200, 350, -75, 100, 80, 50, 120, 100, 80, 50, 120, 1},
    '{10, -300, 0, 500, 90, 0, 70, 90,     90, 0, 70, 90,     0},
    '{0, 0, 0, 0,       127, 10, 60, 127,  127, 127, 60, 127, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CW-1:0] in_chan = '0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic [CW-1:0] out_chan;
  logic signed [DW-1:0] out_data;
  logic [NCH*DW-1:0] est_offset;
  logic [NCH*GW-1:0] est_gain;

  always #4 clk = ~clk;

  oge_equalizer #(.NCH(NCH), .DW(DW), .LOG2N(LOG2N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .est_offset(est_offset), .est_gain(est_gain)
  );

  int n_chk = 0;
  int n_err = 0;
  int exp_y [NSMP];
  bit exp_on [NSMP];
  int out_k = 0;
  logic [2:0] vh = '0;
  longint m_off [NCH];
  longint m_sum [NCH];
  longint m_sq [NCH];
  longint m_pw [NCH];
  int m_cnt [NCH];
  int m_gain [NCH];
  int unsigned lfsr = 32'h1234_5678;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gen_sample(input int off, input int amp);
    int s;
    int v;
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    s = int'(lfsr % 2048) - 1024;
    v = off + ((amp * s) >>> 6);
    if (v > YMAX) v = YMAX;
    if (v < YMIN) v = YMIN;
    return v;
  endfunction

  function automatic int exp_gain(input longint p0, input longint pi);
    longint q;
    longint r;
    if (pi == 0) return 16384;
    if (p0 >= pi * 16) return 65535;
    q = (p0 <<< 28) / pi;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint t = r | (64'sd1 <<< b);
      if (t * t <= q) r = t;
    end
    return int'(r);
  endfunction

  task automatic check_est(input int s);
    for (int c = 0; c < NCH; c++) begin
      check((SCN[s][12] != 0) ? "R3 R9 offset" : "R3 offset",
            longint'($signed(est_offset[c*DW +: DW])), m_off[c]);
      if (c == 0)
        check("R5 gain", longint'(est_gain[c*GW +: GW]), m_gain[c]);
      else if (m_gain[c] == 65535 || m_pw[c] == 0)
        check("R7 gain", longint'(est_gain[c*GW +: GW]), m_gain[c]);
      else
        check("R4 R6 gain", longint'(est_gain[c*GW +: GW]), m_gain[c]);
    end
  endtask

  // input valid history, sampled where the design samples it
  always @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[1:0], in_valid};
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 valid", longint'(out_valid), longint'(vh[2]));
      if (out_valid) begin
        check("R2 chan", longint'(out_chan), longint'(out_k % NCH));
        if (out_k < NSMP && exp_on[out_k])
          check("R8 data", longint'(out_data), longint'(exp_y[out_k]));
        out_k++;
      end
    end
  end

  task automatic run_scn(input int s);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    out_k = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", longint'(out_valid), 0);
    for (int c = 0; c < NCH; c++) begin
      check("R1 offset", longint'($signed(est_offset[c*DW +: DW])), 0);
      check("R1 gain", longint'(est_gain[c*GW +: GW]), 16384);
      m_off[c] = 0; m_sum[c] = 0; m_sq[c] = 0; m_pw[c] = 0;
      m_cnt[c] = 0; m_gain[c] = 16384;
    end
    rst = 1'b0;
    for (int k = 0; k < NSMP; k++) begin
      int c = k % NCH;
      int rd = k / ROUND;
      int pos = k % ROUND;
      int amp;
      int x;
      longint d;
      longint y;
      if (pos == ROUND / 2) check_est(s);
      if (SCN[s][12] != 0 && (k % 7) == 3) begin
        in_valid = 1'b0;
        in_chan  = CW'(k % 3);
        in_data  = DW'(gen_sample(1500, 0));
        @(negedge clk);
      end
      amp = (rd >= 2) ? SCN[s][8 + c] : SCN[s][4 + c];
      x = gen_sample(SCN[s][c], amp);
      d = longint'(x) - m_off[c];
      y = (d * m_gain[c]) >>> 14;
      if (y > YMAX) y = YMAX;
      if (y < YMIN) y = YMIN;
      exp_y[k]  = int'(y);
      exp_on[k] = (pos >= ROUND / 2);
      m_sum[c] += x;
      m_sq[c]  += d * d;
      m_cnt[c]++;
      if (m_cnt[c] == NWIN) begin
        m_off[c] = m_sum[c] >>> LOG2N;
        m_pw[c]  = m_sq[c];
        m_sum[c] = 0;
        m_sq[c]  = 0;
        m_cnt[c] = 0;
        if (c == NCH - 1)
          for (int i = 1; i < NCH; i++) m_gain[i] = exp_gain(m_pw[0], m_pw[i]);
      end
      in_valid = 1'b1;
      in_chan  = CW'(c);
      in_data  = DW'(x);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (200) @(negedge clk);
    check("R2 count", longint'(out_k), longint'(NSMP));
    check_est(s);
  endtask

  initial begin
    for (int s = 0; s < NSCN; s++) run_scn(s);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule